// File: doc/BRIEF.md
# Double-Buffered Converter Code Register Front End

This block is the digital side of a parallel-input digital-to-analog converter. A host processor drives asynchronous pins: an active-low chip select, a read/write select, a data word, a load strobe, a clear strobe and a clear-target select. The block samples every pin with its own system clock through synchronizer chains and holds two registers. The staging register is written and read back by the host. The code register drives the converter ladder.

A rising edge on the load strobe copies the staging register into the code register. The staging register can therefore be rewritten at any time without moving the analog output. A rising edge on the clear strobe forces both registers to zero-scale or to mid-scale. The target is chosen by the select pin, which must be steady around that edge.

The data word is straight binary. The top bit is the most significant bit. The bus is split into an input word, an output word and an output enable, which a pad ring can join into a three-state bus.

Top module: `dbuf_code_frontend`

## Requirements
- R1: While `rst_n` is low, both registers load 0x8000 if `zap_to_mid` is 1 and 0x0000 if it is 0, and `bus_dout_en` is 0.
- R2: A write cycle (`bus_cs_n` low while `bus_rd_wr_n` is 0) commits the last sampled `bus_din` word into the staging register when `bus_cs_n` returns high.
- R3: While `bus_cs_n` is low and `bus_rd_wr_n` is 1, `bus_dout_en` is 1 and `bus_dout` equals the staging register, with bit 15 as the most significant bit.
- R4: While `bus_cs_n` is high, `bus_dout_en` is 0 and `bus_dout` is all zeros.
- R5: `dac_code` changes only on a rising edge of `load_strobe` or `zap_strobe`. A load edge copies the staging register into it, and writes to the staging register leave it untouched.
- R6: Transfer is edge-triggered. Holding `load_strobe` high while the staging register is rewritten does not change `dac_code`.
- R7: A rising edge of `zap_strobe` sets both registers to 0x8000 when `zap_to_mid` is 1, and to 0x0000 when it is 0.
- R8: A clear edge wins over a load edge and over a write commit that are detected in the same clock cycle.
- R9: A read cycle (`bus_rd_wr_n` 1 for the whole cycle) does not alter the staging register when `bus_cs_n` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rd_wr_n | input | 1 | 1 = read, 0 = write |
| bus_din | input | 16 | Data word from host |
| bus_dout | output | 16 | Readback word, zero when not driving |
| bus_dout_en | output | 1 | Output enable for the bus pads |
| load_strobe | input | 1 | Rising edge transfers staging to code register |
| zap_strobe | input | 1 | Rising edge clears both registers |
| zap_to_mid | input | 1 | Clear target: 1 = 0x8000, 0 = 0x0000 |
| dac_code | output | 16 | Code driving the converter |

## Verification
The hardest case to reach is the collision of a clear edge with a load edge and a pending write commit in the same synchronized cycle. From the ports this only happens if all three pins move together. The bench raises `bus_cs_n`, `load_strobe` and `zap_strobe` in the same cycle, at the end of a write whose data differs from both clear values. Because the three pins pass through equal-length synchronizer chains, their edges arrive together, and the result is then read back through a normal read cycle. The main path is swept over all one-hot words and a run of arithmetic patterns, so every data bit goes through staging, readback and transfer.

// File: rtl/dbuf_pkg.sv
`timescale 1ns/1ps
package dbuf_pkg;
   parameter int unsigned DBUF_DEF_WIDTH  = 16;
   parameter int unsigned DBUF_DEF_STAGES = 2;

   // events produced by the control path, consumed by the register path
   typedef struct packed {
      logic capture;    // a write is in progress: refresh the shadow word
      logic commit;     // write cycle ended: move shadow into staging
      logic load_rise;  // transfer staging into code register
      logic zap_rise;   // clear both registers
      logic zap_mid;    // clear target select, synchronized
   } dbuf_evt_t;
endpackage

// File: rtl/dbuf_sync.sv
`timescale 1ns/1ps
module dbuf_sync #(
   parameter int unsigned W       = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dbuf_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain[s] <= RST_VAL;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dbuf_ctrl.sv
`timescale 1ns/1ps
module dbuf_ctrl
   import dbuf_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cs_n_s,
   input  logic      rd_s,
   input  logic      load_s,
   input  logic      zap_s,
   input  logic      mid_s,
   output dbuf_evt_t evt,
   output logic      oe
);
   logic cs_n_prev, load_prev, zap_prev, wr_pend, oe_q;
   logic cs_rise;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs_n_prev <= 1'b1;
         load_prev <= 1'b0;
         zap_prev  <= 1'b0;
         wr_pend   <= 1'b0;
         oe_q      <= 1'b0;
      end else begin
         cs_n_prev <= cs_n_s;
         load_prev <= load_s;
         zap_prev  <= zap_s;
         oe_q      <= !cs_n_s && rd_s;
         if (!cs_n_s && !rd_s) wr_pend <= 1'b1;
         else if (cs_rise)     wr_pend <= 1'b0;
      end
   end

   assign cs_rise       = cs_n_s && !cs_n_prev;
   assign evt.capture   = !cs_n_s && !rd_s;
   assign evt.commit    = cs_rise && wr_pend;
   assign evt.load_rise = load_s && !load_prev;
   assign evt.zap_rise  = zap_s && !zap_prev;
   assign evt.zap_mid   = mid_s;
   assign oe            = oe_q;

   // R4: a deselected bus is released on the next cycle
   a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |=> !oe);
   // R6: a held strobe produces a single transfer event
   a_r6_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
      evt.load_rise |=> !evt.load_rise);
endmodule

// File: rtl/dbuf_regs.sv
`timescale 1ns/1ps
module dbuf_regs
   import dbuf_pkg::*;
#(
   parameter int unsigned W = DBUF_DEF_WIDTH
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         mid_raw,
   input  logic [W-1:0] din_s,
   input  dbuf_evt_t    evt,
   output logic [W-1:0] stage_word,
   output logic [W-1:0] code_word
);
   localparam logic [W-1:0] MID_CODE  = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] ZERO_CODE = '0;

   logic [W-1:0] shadow_q, stage_q, code_q;
   logic [W-1:0] clr_val;

   assign clr_val = evt.zap_mid ? MID_CODE : ZERO_CODE;

   always_ff @(posedge clk) begin
      if (!rst_n)           shadow_q <= '0;
      else if (evt.capture) shadow_q <= din_s;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_q <= mid_raw ? MID_CODE : ZERO_CODE;
         code_q  <= mid_raw ? MID_CODE : ZERO_CODE;
      end else if (evt.zap_rise) begin
         stage_q <= clr_val;
         code_q  <= clr_val;
      end else begin
         if (evt.commit)    stage_q <= shadow_q;
         if (evt.load_rise) code_q  <= stage_q;
      end
   end

   assign stage_word = stage_q;
   assign code_word  = code_q;

   // R1: leaving reset, both registers hold the same legal clear value
   a_r1_init: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (stage_q == code_q) &&
                       (code_q == MID_CODE || code_q == ZERO_CODE));
   // R2: staging moves only on commit or clear
   a_r2_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt.zap_rise && !evt.commit) |=> $stable(stage_q));
   // R5: code moves only on load or clear
   a_r5_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt.zap_rise && !evt.load_rise) |=> $stable(code_q));
   // R7: clear lands on the selected value
   a_r7_clear_val: assert property (@(posedge clk) disable iff (!rst_n)
      evt.zap_rise |=> code_q == ($past(evt.zap_mid) ? MID_CODE : ZERO_CODE));
   // R8: clear beats a same-cycle load or commit
   a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.zap_rise && (evt.load_rise || evt.commit)) |=> stage_q == code_q);
endmodule

// File: rtl/dbuf_code_frontend.sv
`timescale 1ns/1ps
module dbuf_code_frontend
   import dbuf_pkg::*;
#(
   parameter int unsigned WIDTH  = DBUF_DEF_WIDTH,
   parameter int unsigned STAGES = DBUF_DEF_STAGES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_cs_n,
   input  logic             bus_rd_wr_n,
   input  logic [WIDTH-1:0] bus_din,
   output logic [WIDTH-1:0] bus_dout,
   output logic             bus_dout_en,
   input  logic             load_strobe,
   input  logic             zap_strobe,
   input  logic             zap_to_mid,
   output logic [WIDTH-1:0] dac_code
);
   localparam int unsigned NCTL = 5;
   // control pin order: {mid, zap, load, rd, cs_n}; cs_n idles high
   localparam logic [NCTL-1:0] CTL_RST = 5'b00001;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("dbuf_code_frontend: WIDTH must be at least 2");
      end
   endgenerate

   logic [NCTL-1:0]  ctl_s;
   logic [WIDTH-1:0] din_s, stage_word;
   dbuf_evt_t        evt;
   logic             oe;

   dbuf_sync #(.W(NCTL), .STAGES(STAGES), .RST_VAL(CTL_RST)) u_ctl_sync (
      .clk(clk), .rst_n(rst_n),
      .d({zap_to_mid, zap_strobe, load_strobe, bus_rd_wr_n, bus_cs_n}),
      .q(ctl_s)
   );

   dbuf_sync #(.W(WIDTH), .STAGES(STAGES), .RST_VAL('0)) u_data_sync (
      .clk(clk), .rst_n(rst_n), .d(bus_din), .q(din_s)
   );

   dbuf_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cs_n_s(ctl_s[0]), .rd_s(ctl_s[1]), .load_s(ctl_s[2]),
      .zap_s(ctl_s[3]), .mid_s(ctl_s[4]),
      .evt(evt), .oe(oe)
   );

   dbuf_regs #(.W(WIDTH)) u_regs (
      .clk(clk), .rst_n(rst_n), .mid_raw(zap_to_mid), .din_s(din_s),
      .evt(evt), .stage_word(stage_word), .code_word(dac_code)
   );

   assign bus_dout_en = oe;
   assign bus_dout    = oe ? stage_word : '0;

   // R3: whenever the pads drive, the word is the staging register
   a_r3_readback: assert property (@(posedge clk) disable iff (!rst_n)
      bus_dout_en |-> bus_dout == stage_word);
endmodule

// File: tb/dbuf_code_frontend_tb.sv
`timescale 1ns/1ps
module dbuf_code_frontend_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, rw = 1'b1, ld = 1'b0, zp = 1'b0, sel = 1'b1;
   logic [15:0] din = '0;
   logic [15:0] dout, code;
   logic        oe;
   int          n_run = 0, n_fail = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   dbuf_code_frontend u_dut (
      .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_rd_wr_n(rw),
      .bus_din(din), .bus_dout(dout), .bus_dout_en(oe),
      .load_strobe(ld), .zap_strobe(zp), .zap_to_mid(sel), .dac_code(code)
   );

   task automatic wait_cy(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [15:0] v);
      cs_n = 1'b0; rw = 1'b0; din = v; wait_cy(5);
      cs_n = 1'b1; wait_cy(5);
      rw = 1'b1;
   endtask

   task automatic rd(output logic [15:0] v, output logic en);
      rw = 1'b1; cs_n = 1'b0; wait_cy(5);
      v = dout; en = oe;
      cs_n = 1'b1; wait_cy(5);
   endtask

   task automatic load();
      ld = 1'b1; wait_cy(5);
      ld = 1'b0; wait_cy(5);
   endtask

   task automatic zap(input logic s);
      sel = s; wait_cy(4);
      zp = 1'b1; wait_cy(5);
      zp = 1'b0; wait_cy(4);
   endtask

   initial begin
      logic [15:0] rv, prev_code;
      logic        en;
      wait_cy(6);
      // R1: reset with select high
      chk("R1 code", code, 16'h8000);
      chk("R1 oe", {15'd0, oe}, 16'd0);
      rst_n = 1'b1; wait_cy(6);
      rd(rv, en);
      chk("R1 stage", rv, 16'h8000);
      chk("R3 oe during read", {15'd0, en}, 16'd1);
      // R4: deselected bus
      chk("R4 oe idle", {15'd0, oe}, 16'd0);
      chk("R4 dout idle", dout, 16'h0000);

      // R2/R3/R5 sweep: one-hot words then arithmetic patterns
      prev_code = code;
      for (int i = 0; i < 16 + 48; i++) begin
         logic [15:0] v;
         v = (i < 16) ? (16'h1 << i) : 16'((i - 16) * 16'h1357 + 16'h0F0F);
         wr(v);
         chk("R5 code unchanged by write", code, prev_code);
         rd(rv, en);
         chk("R2/R3 readback", rv, v);
         load();
         chk("R5 code after load", code, v);
         prev_code = v;
      end

      // R9: a read cycle leaves staging alone
      din = 16'hDEAD;
      rd(rv, en); rd(rv, en);
      chk("R9 read no write", rv, prev_code);

      // R6: held load strobe is not a level transfer
      ld = 1'b1; wait_cy(6);
      wr(16'h1234);
      wait_cy(6);
      chk("R6 held load", code, prev_code);
      ld = 1'b0; wait_cy(5);
      load();
      chk("R6 next edge", code, 16'h1234);

      // R7: clear to zero and to mid-scale
      wr(16'h4321);
      zap(1'b0);
      chk("R7 zero code", code, 16'h0000);
      rd(rv, en);
      chk("R7 zero stage", rv, 16'h0000);
      wr(16'h7777); load();
      zap(1'b1);
      chk("R7 mid code", code, 16'h8000);
      rd(rv, en);
      chk("R7 mid stage", rv, 16'h8000);

      // R8: clear, load and write commit all in the same cycle
      wr(16'h5A5A);
      sel = 1'b0; wait_cy(4);
      cs_n = 1'b0; rw = 1'b0; din = 16'hC3C3; wait_cy(5);
      cs_n = 1'b1; ld = 1'b1; zp = 1'b1; wait_cy(6);
      ld = 1'b0; zp = 1'b0; rw = 1'b1; wait_cy(4);
      chk("R8 code", code, 16'h0000);
      rd(rv, en);
      chk("R8 stage", rv, 16'h0000);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule